// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is one programmable logic element meant to be repeated across a small reconfigurable fabric. It computes any Boolean function of four inputs through a 16-entry truth table and carries two flip-flops. A two-bit mode field chooses how the function result and a separate bypass input reach the two outputs: combinational, registered, or as a two-stage pipeline.

The truth table and the mode field live in an 18-bit configuration shift register. One bit enters per clock while the configuration enable is high, and the far end of the register leaves on a shift-out pin, so neighbouring elements can be chained into one long configuration path. The configuration holds whenever shifting is off, and the functional reset leaves it alone. For test, a scan enable turns the two flip-flops into a two-bit shift register with its own serial input and output, so their state can be forced and observed.

All storage runs on one clock. The flip-flops use an active-low reset that acts only at a clock edge.

Top module: `cle_logic_element`

## Requirements
- R1: The LUT result equals truth-table bit `tt[idx]`, where `idx` is the 4-bit value on `lut_in` with `lut_in[0]` as the least significant bit; in modes 00 and 11 this result appears combinationally on `out_a`.
- R2: In mode 00, `out_b` shows the LUT result registered one clock earlier.
- R3: In mode 01, `out_a` shows the LUT result registered one clock earlier and `out_b` shows `byp_in` registered one clock earlier.
- R4: In mode 10, the LUT result passes through both flip-flops in series: `out_a` lags it by one clock and `out_b` lags `out_a` by one clock.
- R5: In mode 11, `out_a` is the combinational LUT result and `out_b` follows `byp_in` combinationally.
- R6: While `cfg_en` is high, the 18-bit configuration word shifts one place per clock: `cfg_si` enters bit 0, every bit moves up one place, and `cfg_so` shows bit 17. Bits 15..0 are the truth table (bit i for index i) and bits 17..16 the mode, so a word is loaded by sending bit 17 first; a following load pushes the previous word out on `cfg_so`, bit 17 first.
- R7: While `cfg_en` is low the configuration holds, whatever `cfg_si` and `rst_n` do.
- R8: When `rst_n` is low at a clock edge both flip-flops become 0; a change of `rst_n` between edges does not alter the outputs.
- R9: When `scan_en` is high (and `rst_n` high) the first flip-flop takes `scan_si` and the second takes the first's old value instead of functional data; `scan_so` always shows the second flip-flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all storage |
| rst_n | input | 1 | Active-low synchronous reset of the two flip-flops |
| cfg_en | input | 1 | Shift the configuration register one place this clock |
| cfg_si | input | 1 | Serial configuration input |
| cfg_so | output | 1 | Serial configuration output (bit 17) |
| scan_en | input | 1 | Test mode: flip-flops form a scan chain |
| scan_si | input | 1 | Scan chain serial input |
| scan_so | output | 1 | Scan chain serial output (second flip-flop) |
| lut_in | input | 4 | LUT select inputs, bit 0 least significant |
| byp_in | input | 1 | Bypass data input |
| out_a | output | 1 | First element output |
| out_b | output | 1 | Second element output |

## Verification
On every cycle the assertions watch the configuration path (one place per clock while enabled, frozen otherwise), the reset clearing both flip-flops at an edge, the scan shift order, and the one-clock relations of the registered bypass in mode 01 and the pipeline in mode 10. Whether the LUT picks the right truth-table bit, that the combinational modes follow their inputs without delay, that a reset change between edges leaves the outputs alone, and that a full reload pushes the old word out in order can only be shown by the bench's directed and random scenarios against its own expected values.

// File: rtl/cle_pkg.sv
`timescale 1ns/1ps
package cle_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_COMB_REG  = 2'b00,
      MODE_REG_REG   = 2'b01,
      MODE_PIPE      = 2'b10,
      MODE_COMB_COMB = 2'b11
   } cle_mode_e;
endpackage

// File: rtl/cle_cfg_chain.sv
`timescale 1ns/1ps
module cle_cfg_chain #(
   parameter int LEN = 18
) (
   input  logic           clk,
   input  logic           shift_en,
   input  logic           ser_in,
   output logic           ser_out,
   output logic [LEN-1:0] word_q
);
   // configuration storage is deliberately outside the functional reset
   always_ff @(posedge clk) begin
      if (shift_en) begin
         word_q <= {word_q[LEN-2:0], ser_in};
      end
   end

   assign ser_out = word_q[LEN-1];
endmodule

// File: rtl/cle_lut.sv
`timescale 1ns/1ps
module cle_lut #(
   parameter int K    = 4,
   parameter bit TREE = 1'b1
) (
   input  logic [(1<<K)-1:0] tt,
   input  logic [K-1:0]      sel,
   output logic              y
);
   localparam int N = 1 << K;

   generate
      if (TREE) begin : g_tree
         // heap-ordered 2:1 mux tree, root at node 0, leaves at N-1 .. 2N-2
         logic node [0:2*N-2];
         for (genvar i = 0; i < N; i++) begin : g_leaf
            assign node[N-1+i] = tt[i];
         end
         for (genvar d = 0; d < K; d++) begin : g_lvl
            for (genvar j = 0; j < (1 << d); j++) begin : g_mux
               localparam int P = (1 << d) - 1 + j;
               assign node[P] = sel[K-1-d] ? node[2*P+2] : node[2*P+1];
            end
         end
         assign y = node[0];
      end else begin : g_index
         assign y = tt[sel];
      end
   endgenerate
endmodule

// File: rtl/cle_ff_pair.sv
`timescale 1ns/1ps
module cle_ff_pair
   import cle_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scan_en,
   input  logic      scan_si,
   input  cle_mode_e mode,
   input  logic      lut_y,
   input  logic      byp,
   output logic      q1,
   output logic      q2
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q1 <= 1'b0;
         q2 <= 1'b0;
      end else if (scan_en) begin
         q1 <= scan_si;
         q2 <= q1;
      end else begin
         q1 <= lut_y;
         case (mode)
            MODE_REG_REG: q2 <= byp;
            MODE_PIPE:    q2 <= q1;
            default:      q2 <= q2;
         endcase
      end
   end
endmodule

// File: rtl/cle_logic_element.sv
`timescale 1ns/1ps
module cle_logic_element
   import cle_pkg::*;
#(
   parameter int LUT_K    = 4,
   parameter bit LUT_TREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_si,
   output logic             cfg_so,
   input  logic             scan_en,
   input  logic             scan_si,
   output logic             scan_so,
   input  logic [LUT_K-1:0] lut_in,
   input  logic             byp_in,
   output logic             out_a,
   output logic             out_b
);
   localparam int TT_BITS = 1 << LUT_K;
   localparam int CFG_LEN = TT_BITS + MODE_W;

   generate
      if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
         $error("cle_logic_element: LUT_K must lie in 2..6");
      end
   endgenerate

   logic [CFG_LEN-1:0] cfg_q;
   cle_mode_e          mode;
   logic               lut_y;
   logic               q1;
   logic               q2;

   cle_cfg_chain #(.LEN(CFG_LEN)) i_cfg (
      .clk      (clk),
      .shift_en (cfg_en),
      .ser_in   (cfg_si),
      .ser_out  (cfg_so),
      .word_q   (cfg_q)
   );

   assign mode = cle_mode_e'(cfg_q[CFG_LEN-1 -: MODE_W]);

   cle_lut #(.K(LUT_K), .TREE(LUT_TREE)) i_lut (
      .tt  (cfg_q[TT_BITS-1:0]),
      .sel (lut_in),
      .y   (lut_y)
   );

   cle_ff_pair i_ffs (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .scan_si (scan_si),
      .mode    (mode),
      .lut_y   (lut_y),
      .byp     (byp_in),
      .q1      (q1),
      .q2      (q2)
   );

   always_comb begin
      case (mode)
         MODE_COMB_REG:  begin out_a = lut_y; out_b = q1;     end
         MODE_REG_REG:   begin out_a = q1;    out_b = q2;     end
         MODE_PIPE:      begin out_a = q1;    out_b = q2;     end
         default:        begin out_a = lut_y; out_b = byp_in; end
      endcase
   end

   assign scan_so = q2;
endmodule

// File: rtl/cle_logic_element_chk.sv
`timescale 1ns/1ps
module cle_logic_element_chk #(
   parameter int CFG_LEN = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_en,
   input logic               cfg_so,
   input logic [CFG_LEN-1:0] cfg_q,
   input logic               scan_en,
   input logic               scan_si,
   input logic               scan_so,
   input logic               byp_in,
   input logic               out_a,
   input logic               out_b,
   input logic [1:0]         mode,
   input logic               ff1_q,
   input logic               ff2_q
);
   // R6
   cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> (cfg_so == $past(cfg_q[CFG_LEN-2])));

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(cfg_q));

   // R8
   sync_reset_chk: assert property (@(posedge clk)
      !rst_n |=> (ff1_q == 1'b0 && ff2_q == 1'b0));

   // R9
   scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> (ff1_q == $past(scan_si) && scan_so == $past(ff1_q)));

   // R3
   reg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !cfg_en && !scan_en) |=> (out_b == $past(byp_in)));

   // R4
   pipe_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !cfg_en && !scan_en) |=> (out_b == $past(out_a)));
endmodule

bind cle_logic_element cle_logic_element_chk #(.CFG_LEN(CFG_LEN)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_en  (cfg_en),
   .cfg_so  (cfg_so),
   .cfg_q   (cfg_q),
   .scan_en (scan_en),
   .scan_si (scan_si),
   .scan_so (scan_so),
   .byp_in  (byp_in),
   .out_a   (out_a),
   .out_b   (out_b),
   .mode    (mode),
   .ff1_q   (q1),
   .ff2_q   (q2)
);

// File: tb/test_cle_logic_element.sv
`timescale 1ns/1ps
module test_cle_logic_element;
   localparam int L = 18;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, cfg_en, cfg_si, scan_en, scan_si, byp_in;
   logic [3:0] lut_in;
   logic       cfg_so, scan_so, out_a, out_b;

   cle_logic_element i_cle_logic_element (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_si(cfg_si), .cfg_so(cfg_so),
      .scan_en(scan_en), .scan_si(scan_si), .scan_so(scan_so),
      .lut_in(lut_in), .byp_in(byp_in), .out_a(out_a), .out_b(out_b)
   );

   logic [L-1:0] m_cfg = '0;
   logic         m1 = 1'b0, m2 = 1'b0;
   int           n_chk = 0, n_bad = 0;
   bit           done = 1'b0;

   function automatic logic f_lut(input logic [L-1:0] c, input logic [3:0] i);
      return c[i];
   endfunction

   function automatic logic exp_a();
      logic [1:0] md = m_cfg[17:16];
      return (md == 2'b00 || md == 2'b11) ? f_lut(m_cfg, lut_in) : m1;
   endfunction

   function automatic logic exp_b();
      case (m_cfg[17:16])
         2'b00:   return m1;
         2'b11:   return byp_in;
         default: return m2;
      endcase
   endfunction

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic chk_all(input string req);
      #1;
      chk(req, out_a, exp_a());
      chk(req, out_b, exp_b());
      chk("R9", scan_so, m2);
      chk("R6", cfg_so, m_cfg[L-1]);
   endtask

   task automatic tick();
      logic n1, n2, lv;
      logic [1:0] md;
      lv = f_lut(m_cfg, lut_in);
      md = m_cfg[17:16];
      if (!rst_n) begin
         n1 = 1'b0; n2 = 1'b0;
      end else if (scan_en) begin
         n1 = scan_si; n2 = m1;
      end else begin
         n1 = lv;
         n2 = (md == 2'b01) ? byp_in : (md == 2'b10) ? m1 : m2;
      end
      @(posedge clk);
      #1;
      if (cfg_en) m_cfg = {m_cfg[L-2:0], cfg_si};
      m1 = n1;
      m2 = n2;
   endtask

   task automatic load_cfg(input logic [L-1:0] w, input bit do_chk);
      cfg_en = 1'b1;
      for (int i = L-1; i >= 0; i--) begin
         cfg_si = w[i];
         tick();
         if (do_chk) begin
            #1;
            chk("R6", cfg_so, m_cfg[L-1]);
         end
      end
      cfg_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [L-1:0] wa, wb;
      string tags [4];
      tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
      void'($urandom(32'd4242));
      rst_n = 1'b0; cfg_en = 1'b0; cfg_si = 1'b0; scan_en = 1'b0;
      scan_si = 1'b0; byp_in = 1'b0; lut_in = '0;

      // first load under reset: model becomes exact afterwards
      load_cfg({2'b01, 16'h9E37}, 1'b0);
      tick(); tick();
      #1;
      chk("R8", out_a, 1'b0);
      chk("R8", out_b, 1'b0);
      chk("R8", scan_so, 1'b0);
      rst_n = 1'b1;

      // R1: single-bit truth tables, input bit 0 least significant
      load_cfg({2'b11, 16'h0001}, 1'b1);
      for (int i = 0; i < 16; i++) begin
         lut_in = 4'(i);
         byp_in = i[0];
         #1;
         chk("R1", out_a, (i == 0));
         chk("R5", out_b, i[0]);
      end
      load_cfg({2'b11, 16'h0002}, 1'b1);
      lut_in = 4'b0001; #1; chk("R1", out_a, 1'b1);
      lut_in = 4'b0010; #1; chk("R1", out_a, 1'b0);

      // R6: a reload pushes the old word out, bit 17 first
      wa = {2'b10, 16'h5C3A};
      wb = {2'b01, 16'hA3C5};
      load_cfg(wa, 1'b1);
      cfg_en = 1'b1;
      for (int i = 0; i < L; i++) begin
         #1;
         chk("R6", cfg_so, wa[L-1-i]);
         cfg_si = wb[L-1-i];
         tick();
      end
      cfg_en = 1'b0;

      // random traffic in each mode
      for (int md = 0; md < 4; md++) begin
         load_cfg({2'(md), 16'($urandom)}, 1'b1);
         for (int c = 0; c < 40; c++) begin
            lut_in = 4'($urandom);
            byp_in = 1'($urandom);
            chk_all(tags[md]);
            tick();
         end
      end

      // R7: config holds through cfg_si noise and reset pulses
      load_cfg({2'b11, 16'hA55A}, 1'b1);
      for (int c = 0; c < 24; c++) begin
         cfg_si = 1'($urandom);
         rst_n  = (c % 5 != 2);
         lut_in = 4'($urandom);
         tick();
         #1;
         chk("R7", cfg_so, 1'b1);
         chk("R7", out_a, f_lut({2'b11, 16'hA55A}, lut_in));
      end
      rst_n = 1'b1;

      // R8: reset acts only at the edge
      load_cfg({2'b01, 16'hFFFF}, 1'b1);
      lut_in = 4'd0; byp_in = 1'b1;
      tick(); tick();
      #1;
      chk("R3", out_a, 1'b1);
      chk("R3", out_b, 1'b1);
      rst_n = 1'b0;
      #1;
      chk("R8", out_a, 1'b1);
      chk("R8", out_b, 1'b1);
      tick();
      #1;
      chk("R8", out_a, 1'b0);
      chk("R8", out_b, 1'b0);
      rst_n = 1'b1;

      // R9: scan overrides functional data (LUT would give 1)
      scan_en = 1'b1;
      scan_si = 1'b1; tick(); #1;
      chk("R9", out_a, 1'b1);
      chk("R9", scan_so, 1'b0);
      scan_si = 1'b0; tick(); #1;
      chk("R9", out_a, 1'b0);
      chk("R9", scan_so, 1'b1);
      for (int c = 0; c < 30; c++) begin
         scan_si = 1'($urandom);
         lut_in  = 4'($urandom);
         byp_in  = 1'($urandom);
         chk_all("R9");
         tick();
      end
      scan_en = 1'b0;
      chk_all("R3");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule